// File: doc/BRIEF.md
# Three-Channel Compare General-Purpose Timer

An up-counting timer peripheral behind a small word-addressed register bus. A 3-bit field in the control register picks one of up to eight clock-source codes. Each code is either the bus clock itself, one of three single-cycle enable pulses from the chip (high-rate, slow and external), or no clock at all. A 12-bit prescaler divides the chosen source by (prescaler + 1) before the counter advances.

Three compare channels watch the counter. Each channel raises its own status flag when the counter takes the channel's value, and a fourth flag records a wrap from all-ones. The flags are cleared by writing ones to them. One level-sensitive interrupt line reports any flag whose enable bit is set, but only while the timer is enabled. In restart mode the first channel sets the period, because the counter returns to zero on the tick after it equals compare 1. In free-run mode the counter runs through its full range. Capture registers are read-only placeholders that read as zero.

Top module: `gp_timer`

## Requirements
- R1: Register map (byte offsets): control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 1/2/3 at 0x10/0x14/0x18, capture 0x1C/0x20 (always read 0), counter 0x24 (read-only). All other offsets read 0 and ignore writes. A control write drops the bits in mask 0x7C14. The prescaler keeps bits 11:0 and the interrupt enable keeps bits 5:0. Read data appears on `bus_rdata` one cycle after the read strobe.
- R2: After reset, control, prescaler, status, interrupt enable and counter read 0, and each compare register reads all-ones of the counter width.
- R3: Control bit 0 is enable and bits 8:6 select the source; code 1 is every bus clock. While enabled, the counter advances once every (prescaler + 1) source pulses. The prescaler phase restarts from zero while the timer is disabled or when the prescaler is written.
- R4: Source code 0, and any code not marked valid by the `VALID_SRC` parameter (codes 3, 5, 6 and 7 by default), leave the counter unchanged.
- R5: With control bit 9 (free-run) set, the counter wraps from all-ones to 0. A tick taken at all-ones sets status bit 5.
- R6: With control bit 9 clear (restart mode), a tick taken while the counter equals compare 1 loads 0.
- R7: A write to compare 1 while in restart mode sets the counter to 0. In free-run mode it leaves the counter unchanged.
- R8: A control write that turns bit 0 from 0 to 1 with bit 1 (enable-mode) set loads the counter with 0. Without bit 1, counting resumes from the held value.
- R9: Status bits 0, 1 and 2 are set when a tick moves the counter onto compare 1, 2 and 3. Status bits 3 and 4 are never set.
- R10: A status write clears every bit written as 1 and leaves bits written as 0 unchanged. A flag raised in the same cycle wins over the clear.
- R11: `irq` is high exactly when (status AND interrupt enable) is nonzero and control bit 0 is set.
- R12: A control write with bit 15 set resets the block except for the configuration. It stores the written value with bits 5:0 and bit 15 cleared (bit 15 reads back 0), and it resets prescaler, status, interrupt enable, counter and compare registers as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_hf_pulse | input | 1 | High-rate source enable pulse (code 2) |
| src_ext_pulse | input | 1 | External source enable pulse (code 3) |
| src_slow_pulse | input | 1 | Slow source enable pulse (codes 4 to 7) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with an 8-bit counter (`CNT_W = 8`) and keeps the default source mask. With 8 bits, a run of a few hundred cycles passes every compare value, reaches all-ones and wraps. This makes the rollover flag and the reset value of the compare registers observable in a short run. The default mask leaves code 3 invalid, so the bench can show that an undefined source freezes the counter. It also drives runs through the bus clock source with prescaler values 0 and 3.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PSC_W   = 12;
  localparam int unsigned FLAG_W  = 6;
  localparam int unsigned NCMP    = 3;
  localparam int unsigned NSRC    = 8;

  localparam logic [3:0] W_CTRL = 4'd0;
  localparam logic [3:0] W_PSC  = 4'd1;
  localparam logic [3:0] W_STAT = 4'd2;
  localparam logic [3:0] W_IE   = 4'd3;
  localparam logic [3:0] W_CMP1 = 4'd4;
  localparam logic [3:0] W_CMP2 = 4'd5;
  localparam logic [3:0] W_CMP3 = 4'd6;
  localparam logic [3:0] W_CAP1 = 4'd7;
  localparam logic [3:0] W_CAP2 = 4'd8;
  localparam logic [3:0] W_CNT  = 4'd9;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_ENMOD = 1;
  localparam int unsigned B_SRC   = 6;
  localparam int unsigned B_FRR   = 9;
  localparam int unsigned B_SWR   = 15;
  localparam int unsigned F_ROV   = 5;

  localparam logic [DATA_W-1:0] CTRL_DROP  = 32'h0000_7C14;
  localparam logic [DATA_W-1:0] CTRL_RSTCL = 32'h0000_803F;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int unsigned PW = PSC_W,
  parameter logic [NSRC-1:0] VALID_SRC = 8'b0001_0110
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [2:0]      src_sel,
  input  logic [NSRC-1:0] src_vec,
  input  logic [PW-1:0]   psc,
  output logic            tick
);
  logic [NSRC-1:0] src_ok;
  logic [PW-1:0]   phase_q;
  logic            pulse;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (VALID_SRC[g]) begin : g_on
      assign src_ok[g] = src_vec[g];
    end else begin : g_off
      assign src_ok[g] = 1'b0;
    end
  end

  assign pulse = run & src_ok[src_sel];
  assign tick  = pulse & (phase_q == psc);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      phase_q <= '0;
    end else if (pulse) begin
      phase_q <= (phase_q == psc) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    zero_ld,
  input  logic                    restart,
  input  logic [NCMP-1:0][CW-1:0] cmp,
  output logic [CW-1:0]           cnt,
  output logic [NCMP-1:0]         hit,
  output logic                    wrap
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nxt;

  always_comb begin
    if (restart && (cnt_q == cmp[0])) nxt = '0;
    else                              nxt = cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = tick & ~zero_ld & (nxt == cmp[i]);
  end

  assign wrap = tick & ~zero_ld & (&cnt_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || zero_ld) cnt_q <= '0;
    else if (tick)      cnt_q <= nxt;
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 6,
  parameter logic [NSRC-1:0] VALID_SRC = 8'b0001_0110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              src_hf_pulse,
  input  logic              src_ext_pulse,
  input  logic              src_slow_pulse,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0]          ctrl_q, ctrl_d;
  logic [PSC_W-1:0]           psc_q;
  logic [FLAG_W-1:0]          stat_q, stat_d, ie_q, ie_d, set_bits, clr_bits;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [NCMP-1:0]            hit;
  logic                       wrap, tick, zero_ld, en_rise, swr;
  logic [3:0]                 widx;
  logic                       wen, ren;
  logic [DATA_W-1:0]          ctrl_wval;
  logic [NSRC-1:0]            src_vec;

  assign widx = bus_addr[ADDR_W-1:2];
  assign wen  = bus_sel & bus_wr;
  assign ren  = bus_sel & ~bus_wr;

  assign ctrl_wval = bus_wdata & ~CTRL_DROP;
  assign swr       = wen && (widx == W_CTRL) && bus_wdata[B_SWR];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wen && widx == W_CTRL) begin
      ctrl_d = swr ? (ctrl_wval & ~CTRL_RSTCL) : ctrl_wval;
    end
  end

  assign en_rise = ~ctrl_q[B_EN] & ctrl_d[B_EN];
  assign zero_ld = swr
                 | (wen && widx == W_CMP1 && !ctrl_q[B_FRR])
                 | (en_rise & ctrl_d[B_ENMOD]);

  assign src_vec = {{3{src_slow_pulse}}, src_slow_pulse, src_ext_pulse,
                    src_hf_pulse, 1'b1, 1'b0};

  tmr_tick_gen #(.PW(PSC_W), .VALID_SRC(VALID_SRC)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q[B_EN]),
    .clr     (swr | (wen && widx == W_PSC)),
    .src_sel (ctrl_q[B_SRC +: 3]),
    .src_vec (src_vec),
    .psc     (psc_q),
    .tick    (tick)
  );

  tmr_counter #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .zero_ld (zero_ld),
    .restart (~ctrl_q[B_FRR]),
    .cmp     (cmp_q),
    .cnt     (cnt_q),
    .hit     (hit),
    .wrap    (wrap)
  );

  always_comb begin
    set_bits        = '0;
    set_bits[2:0]   = hit;
    set_bits[F_ROV] = wrap;
    clr_bits = (wen && widx == W_STAT) ? bus_wdata[FLAG_W-1:0] : '0;
    stat_d   = swr ? '0 : ((stat_q & ~clr_bits) | set_bits);
    ie_d     = swr ? '0 : ((wen && widx == W_IE) ? bus_wdata[FLAG_W-1:0] : ie_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      stat_q <= '0;
      ie_q   <= '0;
      cmp_q  <= {NCMP{CNT_MAX}};
      irq    <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      ie_q   <= ie_d;
      irq    <= (|(stat_d & ie_d)) & ctrl_d[B_EN];
      if (swr) begin
        psc_q <= '0;
        cmp_q <= {NCMP{CNT_MAX}};
      end else if (wen) begin
        case (widx)
          W_PSC:  psc_q    <= bus_wdata[PSC_W-1:0];
          W_CMP1: cmp_q[0] <= bus_wdata[CNT_W-1:0];
          W_CMP2: cmp_q[1] <= bus_wdata[CNT_W-1:0];
          W_CMP3: cmp_q[2] <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (ren) begin
      case (widx)
        W_CTRL:  bus_rdata <= ctrl_q;
        W_PSC:   bus_rdata <= DATA_W'(psc_q);
        W_STAT:  bus_rdata <= DATA_W'(stat_q);
        W_IE:    bus_rdata <= DATA_W'(ie_q);
        W_CMP1:  bus_rdata <= DATA_W'(cmp_q[0]);
        W_CMP2:  bus_rdata <= DATA_W'(cmp_q[1]);
        W_CMP3:  bus_rdata <= DATA_W'(cmp_q[2]);
        W_CNT:   bus_rdata <= DATA_W'(cnt_q);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             en,
  input logic             frr,
  input logic             tick,
  input logic             zero_ld,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp1,
  input logic [5:0]       stat,
  input logic [5:0]       ie
);
  assert_irq_level_R11: assert property (@(posedge clk) disable iff (rst)
    irq == ((|(stat & ie)) && en));

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    !en |-> !irq);

  assert_capture_flags_R9: assert property (@(posedge clk) disable iff (rst)
    stat[4:3] == 2'b00);

  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !frr && (cnt == cmp1)) |=> (cnt == '0));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !zero_ld) |=> $stable(cnt));
endmodule

bind gp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq),
  .en      (ctrl_q[0]),
  .frr     (ctrl_q[9]),
  .tick    (tick),
  .zero_ld (zero_ld),
  .cnt     (cnt_q),
  .cmp1    (cmp_q[0]),
  .stat    (stat_q),
  .ie      (ie_q)
);

// File: tb/gp_timer_tb_top.sv
module gp_timer_tb_top;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic rd_pend = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  gp_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_hf_pulse(1'b0), .src_ext_pulse(1'b1), .src_slow_pulse(1'b0),
    .irq(irq)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    rd_pend <= bus_sel & ~bus_wr;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      report();
    end
  end

  // monitor: pops the expected read data one cycle after each read
  always @(negedge clk) begin
    if (rd_pend) begin
      item_t it;
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    sb_q.push_back('{e, tag});
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_sel = 0; bus_wr = 0;
      @(posedge clk);
    end
  endtask

  // enable at one edge, disable exactly n edges later
  task automatic run(input logic [31:0] c, input int n);
    wr(6'h00, c);
    idle(n - 1);
    wr(6'h00, c & ~32'h1);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk); bus_sel = 0;
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R2 reset state
    chk_irq(1'b0, "R2 irq");
    rd(6'h00, 0, "R2 ctrl");  rd(6'h04, 0, "R2 psc");
    rd(6'h08, 0, "R2 stat");  rd(6'h0C, 0, "R2 ie");
    rd(6'h10, 32'hFF, "R2 cmp1"); rd(6'h14, 32'hFF, "R2 cmp2");
    rd(6'h18, 32'hFF, "R2 cmp3"); rd(6'h24, 0, "R2 cnt");
    // R1 masks and map
    wr(6'h00, 32'h7C14 | 32'h3C0); rd(6'h00, 32'h3C0, "R1 ctrl mask");
    wr(6'h00, 0);
    wr(6'h04, 32'hFFFF_F123);      rd(6'h04, 32'h123, "R1 psc mask");
    wr(6'h0C, 32'hFF);             rd(6'h0C, 32'h3F, "R1 ie mask");
    wr(6'h0C, 0);
    wr(6'h28, 32'h55);             rd(6'h28, 0, "R1 unmapped");
    rd(6'h1C, 0, "R1 cap1");       rd(6'h20, 0, "R1 cap2");
    // R3 prescaler 3: 20 edges -> 5 ticks; R9 compare 2 at 5
    wr(6'h14, 5); wr(6'h18, 32'h30); wr(6'h04, 3);
    run(32'h243, 20);
    rd(6'h24, 5, "R3 psc3 count");
    rd(6'h08, 32'h02, "R9 cmp2 flag");
    // R8 resume without enable-mode
    wr(6'h04, 0);
    run(32'h241, 10);
    rd(6'h24, 15, "R8 resume count");
    // R4 invalid source 3 and source 0
    run(32'h2C1, 30);  rd(6'h24, 15, "R4 code3");
    run(32'h201, 10);  rd(6'h24, 15, "R4 code0");
    // R11 interrupt gating by enable
    wr(6'h0C, 32'h02);
    chk_irq(1'b0, "R11 disabled");
    wr(6'h00, 32'h241); chk_irq(1'b1, "R11 enabled");
    wr(6'h00, 32'h240); chk_irq(1'b0, "R11 off again");
    // R10 write-one-to-clear
    wr(6'h08, 32'h01); rd(6'h08, 32'h02, "R10 zero bits kept");
    wr(6'h08, 32'h02); rd(6'h08, 0, "R10 cleared");
    wr(6'h0C, 0);
    // R5 free-run wrap: 300 ticks on 8 bits
    run(32'h243, 300);
    rd(6'h24, 44, "R5 wrap count");
    rd(6'h08, 32'h27, "R5 R9 flags");
    wr(6'h08, 32'h3F);
    // R6 restart at compare 1 = 9: 25 ticks -> 5
    wr(6'h10, 9);
    run(32'h043, 25);
    rd(6'h24, 5, "R6 restart count");
    rd(6'h08, 32'h03, "R6 flags");
    // R7 compare 1 write in restart mode zeroes counter
    wr(6'h10, 32'h20); rd(6'h24, 0, "R7 restart write");
    wr(6'h00, 32'h240);
    run(32'h241, 7);
    wr(6'h10, 32'h10); rd(6'h24, 7, "R7 free-run write");
    // R8 enable-mode zeroes
    run(32'h243, 3); rd(6'h24, 3, "R8 enmod zero");
    // R12 software reset
    wr(6'h0C, 32'h3F); wr(6'h04, 7); wr(6'h14, 32'h11);
    wr(6'h00, 32'h8243);
    rd(6'h00, 32'h240, "R12 ctrl kept");
    rd(6'h04, 0, "R12 psc");     rd(6'h0C, 0, "R12 ie");
    rd(6'h08, 0, "R12 stat");    rd(6'h24, 0, "R12 cnt");
    rd(6'h14, 32'hFF, "R12 cmp2"); rd(6'h10, 32'hFF, "R12 cmp1");
    idle(2);
    if (sb_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    report();
  end
endmodule